// File: doc/BRIEF.md
# Three-Bus Microengine Datapath

This block is the register-transfer datapath of a small microprogrammed engine. Each microcycle lasts four clocks, and a counter inside the block marks the four subcycles. In the first subcycle the control fields on the inputs are captured into a microinstruction register. In the second, two registers are read from a sixteen-entry file into the A and B bus latches. In the third, the arithmetic unit and the shifter settle. In the fourth, the result is written back to a register, to the memory buffer, or to both, and the memory address register may load from the B latch.

Five slots of the register file are read-only constants that the microcode uses as masks and increments. The other eleven slots are ordinary storage. The result of each operation updates a negative flag and a zero flag, which a sequencer outside this block uses for branching. The memory buffer register and the memory address register drive the memory data and address outputs. The sequencer that chooses the next microinstruction, and the memory timing, belong to the surrounding design.

Top module: `ucode_datapath`

## Requirements
- R1: Slots 0 to 4 and 10 to 15 are writable, 16 bits wide, and read back as 0 after reset.
- R2: Slots 5, 6, 7, 8 and 9 always read as 0x0000, 0x0001, 0xFFFF, 0x0FFF and 0x00FF.
- R3: A write aimed at slots 5 to 9 leaves the value read from them unchanged.
- R4: The ALU op field selects the operation: 00 gives A+B (modulo 2^16), 01 gives A AND B, 10 passes A, and 11 gives NOT A.
- R5: The shift field selects the shift: 00 leaves the value unchanged, 01 is a logical right shift by one, 10 is a logical left shift by one, and 11 leaves the value unchanged.
- R6: When the A-select bit is 0, the ALU A operand is the A latch. When it is 1, the A operand is the memory buffer register.
- R7: At the fourth subcycle of every microcycle, flag_n takes bit 15 of the ALU result before the shift, and flag_z is 1 exactly when that unshifted result is zero. The flags do not change at any other subcycle.
- R8: When the mar bit is 1, mem_addr loads bits 11:0 of the B latch at the fourth subcycle. When the bit is 0, mem_addr holds its value.
- R9: When the enable bit is 0, no register is written, whatever the destination field holds.
- R10: The source registers are latched at the second subcycle. A microinstruction that reads and writes the same slot uses the old value exactly once.
- R11: mem_data shows the memory buffer register. It loads the shifter output at the fourth subcycle only when the mbr bit is 1.
- R12: phase counts 0, 1, 2, 3 and wraps. The control inputs are captured only at the edge where phase is 0. Synchronous reset returns phase, the flags, mem_addr and mem_data to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| uf_amux | input | 1 | ALU A operand select: 0 selects the A latch, 1 selects the memory buffer |
| uf_alu | input | 2 | ALU operation code |
| uf_shift | input | 2 | Shifter code |
| uf_mbr_ld | input | 1 | Load the memory buffer from the shifter output |
| uf_mar_ld | input | 1 | Load the memory address from the B latch |
| uf_enc | input | 1 | Enable the register write-back |
| uf_csel | input | 4 | Destination register slot |
| uf_bsel | input | 4 | B bus source slot |
| uf_asel | input | 4 | A bus source slot |
| phase | output | 2 | Current subcycle, 0 to 3 |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| mem_addr | output | 12 | Memory address register |
| mem_data | output | 16 | Memory buffer register |

## Verification
Every constant slot is read through a pass-A operation into the memory buffer. This shows that the read selection works and that the constants carry the right values. The operand pairs are chosen so that each ALU code gives a different result, for example 0xFFFF+1 wrapping to zero. The shift cases use operands where the pre-shift flags and the post-shift flags would differ, such as 0x0001 shifted right and 0xFFFF shifted right, so a flag taken after the shifter would be caught. Further patterns check that a read and a write of the same slot use the latched value, that write-backs aimed at the constants or with the enable bit clear leave no trace, that the address and buffer registers hold when their load bits are clear, and that fields changed after the phase-0 edge are ignored.

// File: rtl/dp_pkg.sv
package dp_pkg;

  typedef enum logic [1:0] {
    ALU_ADD  = 2'b00,
    ALU_AND  = 2'b01,
    ALU_PASS = 2'b10,
    ALU_NOT  = 2'b11
  } alu_op_e;

  typedef enum logic [1:0] {
    SH_NONE  = 2'b00,
    SH_RIGHT = 2'b01,
    SH_LEFT  = 2'b10,
    SH_RSVD  = 2'b11
  } shift_op_e;

  localparam int unsigned PHASES = 4;

endpackage

// File: rtl/dp_phase_gen.sv
module dp_phase_gen #(
  parameter int unsigned NPH = dp_pkg::PHASES,
  localparam int unsigned PH_W = $clog2(NPH)
) (
  input  logic            clk,
  input  logic            rst,
  output logic [PH_W-1:0] ph,
  output logic [NPH-1:0]  strobe
);

  logic [PH_W-1:0] ph_q;

  always_ff @(posedge clk) begin
    if (rst) ph_q <= '0;
    else if (ph_q == PH_W'(NPH - 1)) ph_q <= '0;
    else ph_q <= ph_q + 1'b1;
  end

  // one strobe per subcycle
  for (genvar g = 0; g < NPH; g++) begin : g_strobe
    assign strobe[g] = (ph_q == PH_W'(g));
  end

  assign ph = ph_q;

  AST_PHASE_STEP: assert property (@(posedge clk) disable iff (rst)
    (ph_q != PH_W'(NPH - 1)) |=> (ph_q == $past(ph_q) + 1'b1)); // R12
  AST_PHASE_WRAP: assert property (@(posedge clk) disable iff (rst)
    (ph_q == PH_W'(NPH - 1)) |=> (ph_q == '0)); // R12

endmodule

// File: rtl/dp_regfile.sv
module dp_regfile #(
  parameter int unsigned W          = 16,
  parameter int unsigned NREG       = 16,
  parameter int unsigned ADDR_W     = 12,
  parameter int unsigned OFFS_W     = 8,
  parameter int unsigned CONST_BASE = 5,
  parameter int unsigned CONST_CNT  = 5,
  localparam int unsigned SEL_W     = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_en,
  input  logic [SEL_W-1:0] a_idx,
  input  logic [SEL_W-1:0] b_idx,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_idx,
  input  logic [W-1:0]     wr_data,
  output logic [W-1:0]     a_lat,
  output logic [W-1:0]     b_lat
);

  logic [W-1:0] store [NREG];

  function automatic logic is_const(input logic [SEL_W-1:0] idx);
    return (int'(idx) >= int'(CONST_BASE)) &&
           (int'(idx) < int'(CONST_BASE + CONST_CNT));
  endfunction

  // zero, one, all-ones, address mask, offset mask
  function automatic logic [W-1:0] const_val(input logic [SEL_W-1:0] idx);
    logic [W-1:0] v;
    case (int'(idx) - int'(CONST_BASE))
      0:       v = '0;
      1:       v = W'(1);
      2:       v = '1;
      3:       v = W'((64'd1 << ADDR_W) - 64'd1);
      default: v = W'((64'd1 << OFFS_W) - 64'd1);
    endcase
    return v;
  endfunction

  function automatic logic [W-1:0] rd_mux(input logic [SEL_W-1:0] idx,
                                          input logic [W-1:0] stored);
    return is_const(idx) ? const_val(idx) : stored;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < int'(NREG); i++) store[i] <= '0;
    end else if (wr_en && !is_const(wr_idx)) begin
      store[wr_idx] <= wr_data;
    end
  end

  // the bus latches: sampled once per microcycle
  always_ff @(posedge clk) begin
    if (rst) begin
      a_lat <= '0;
      b_lat <= '0;
    end else if (rd_en) begin
      a_lat <= rd_mux(a_idx, store[a_idx]);
      b_lat <= rd_mux(b_idx, store[b_idx]);
    end
  end

  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> ($stable(a_lat) && $stable(b_lat))); // R10
  AST_NO_RW_OVERLAP: assert property (@(posedge clk) disable iff (rst)
    !(rd_en && wr_en)); // R10

endmodule

// File: rtl/dp_alu.sv
module dp_alu
  import dp_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  alu_op_e      alu_op,
  input  shift_op_e    sh_op,
  output logic [W-1:0] result,
  output logic         neg,
  output logic         zero
);

  logic [W-1:0] raw;

  always_comb begin
    case (alu_op)
      ALU_ADD:  raw = op_a + op_b;
      ALU_AND:  raw = op_a & op_b;
      ALU_PASS: raw = op_a;
      default:  raw = ~op_a;
    endcase
  end

  always_comb begin
    case (sh_op)
      SH_RIGHT: result = {1'b0, raw[W-1:1]};
      SH_LEFT:  result = {raw[W-2:0], 1'b0};
      default:  result = raw;
    endcase
  end

  // flags come from the unshifted value
  assign neg  = raw[W-1];
  assign zero = (raw == '0);

endmodule

// File: rtl/ucode_datapath.sv
module ucode_datapath
  import dp_pkg::*;
#(
  parameter int unsigned W          = 16,
  parameter int unsigned NREG       = 16,
  parameter int unsigned ADDR_W     = 12,
  parameter int unsigned OFFS_W     = 8,
  parameter int unsigned CONST_BASE = 5,
  parameter int unsigned CONST_CNT  = 5,
  localparam int unsigned SEL_W     = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              uf_amux,
  input  logic [1:0]        uf_alu,
  input  logic [1:0]        uf_shift,
  input  logic              uf_mbr_ld,
  input  logic              uf_mar_ld,
  input  logic              uf_enc,
  input  logic [SEL_W-1:0]  uf_csel,
  input  logic [SEL_W-1:0]  uf_bsel,
  input  logic [SEL_W-1:0]  uf_asel,
  output logic [1:0]        phase,
  output logic              flag_n,
  output logic              flag_z,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [W-1:0]      mem_data
);

  localparam int unsigned S_FETCH = 0;
  localparam int unsigned S_READ  = 1;
  localparam int unsigned S_WRITE = 3;

  logic [PHASES-1:0] strobe;

  // microinstruction register
  logic              mi_amux, mi_mbr, mi_mar, mi_enc;
  alu_op_e           mi_alu;
  shift_op_e         mi_sh;
  logic [SEL_W-1:0]  mi_c, mi_b, mi_a;

  logic [W-1:0]      a_lat, b_lat, alu_a, sh_out;
  logic              alu_neg, alu_zero;
  logic [W-1:0]      mbr_q;
  logic [ADDR_W-1:0] mar_q;

  dp_phase_gen #(.NPH(PHASES)) u_phase (
    .clk    (clk),
    .rst    (rst),
    .ph     (phase),
    .strobe (strobe)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mi_amux <= 1'b0;
      mi_alu  <= ALU_ADD;
      mi_sh   <= SH_NONE;
      mi_mbr  <= 1'b0;
      mi_mar  <= 1'b0;
      mi_enc  <= 1'b0;
      mi_c    <= '0;
      mi_b    <= '0;
      mi_a    <= '0;
    end else if (strobe[S_FETCH]) begin
      mi_amux <= uf_amux;
      mi_alu  <= alu_op_e'(uf_alu);
      mi_sh   <= shift_op_e'(uf_shift);
      mi_mbr  <= uf_mbr_ld;
      mi_mar  <= uf_mar_ld;
      mi_enc  <= uf_enc;
      mi_c    <= uf_csel;
      mi_b    <= uf_bsel;
      mi_a    <= uf_asel;
    end
  end

  dp_regfile #(
    .W(W), .NREG(NREG), .ADDR_W(ADDR_W), .OFFS_W(OFFS_W),
    .CONST_BASE(CONST_BASE), .CONST_CNT(CONST_CNT)
  ) u_rf (
    .clk     (clk),
    .rst     (rst),
    .rd_en   (strobe[S_READ]),
    .a_idx   (mi_a),
    .b_idx   (mi_b),
    .wr_en   (strobe[S_WRITE] && mi_enc),
    .wr_idx  (mi_c),
    .wr_data (sh_out),
    .a_lat   (a_lat),
    .b_lat   (b_lat)
  );

  assign alu_a = mi_amux ? mbr_q : a_lat;

  dp_alu #(.W(W)) u_alu (
    .op_a   (alu_a),
    .op_b   (b_lat),
    .alu_op (mi_alu),
    .sh_op  (mi_sh),
    .result (sh_out),
    .neg    (alu_neg),
    .zero   (alu_zero)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mbr_q  <= '0;
      mar_q  <= '0;
      flag_n <= 1'b0;
      flag_z <= 1'b0;
    end else if (strobe[S_WRITE]) begin
      flag_n <= alu_neg;
      flag_z <= alu_zero;
      if (mi_mbr) mbr_q <= sh_out;
      if (mi_mar) mar_q <= b_lat[ADDR_W-1:0];
    end
  end

  assign mem_data = mbr_q;
  assign mem_addr = mar_q;

  AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (rst)
    !strobe[S_WRITE] |=> ($stable(flag_n) && $stable(flag_z))); // R7
  AST_MAR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(strobe[S_WRITE] && mi_mar) |=> $stable(mem_addr)); // R8
  AST_MBR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(strobe[S_WRITE] && mi_mbr) |=> $stable(mem_data)); // R11
  AST_MI_HOLD: assert property (@(posedge clk) disable iff (rst)
    !strobe[S_FETCH] |=> ($stable(mi_a) && $stable(mi_c) && $stable(mi_enc))); // R12

endmodule

// File: tb/ucode_datapath_tb.sv
module ucode_datapath_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 27;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic uf_amux = 1'b0, uf_mbr_ld = 1'b0, uf_mar_ld = 1'b0, uf_enc = 1'b0;
  logic [1:0] uf_alu = 2'b00, uf_shift = 2'b00;
  logic [3:0] uf_csel = 4'h0, uf_bsel = 4'h0, uf_asel = 4'h0;
  logic [1:0]  phase;
  logic        flag_n, flag_z;
  logic [11:0] mem_addr;
  logic [15:0] mem_data;

  int n_run = 0;
  int n_fail = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  ucode_datapath u_dut (
    .clk(clk), .rst(rst), .uf_amux(uf_amux), .uf_alu(uf_alu), .uf_shift(uf_shift),
    .uf_mbr_ld(uf_mbr_ld), .uf_mar_ld(uf_mar_ld), .uf_enc(uf_enc),
    .uf_csel(uf_csel), .uf_bsel(uf_bsel), .uf_asel(uf_asel),
    .phase(phase), .flag_n(flag_n), .flag_z(flag_z),
    .mem_addr(mem_addr), .mem_data(mem_data)
  );

  // bench packing {amux, alu, sh, mbr, mar, enc, c, b, a}
  function automatic logic [19:0] mk(input logic am, input logic [1:0] op,
      input logic [1:0] sh, input logic mb, input logic ma, input logic en,
      input logic [3:0] c, input logic [3:0] b, input logic [3:0] a);
    return {am, op, sh, mb, ma, en, c, b, a};
  endfunction

  localparam logic [1:0] ADD = 2'b00, AND = 2'b01, PAS = 2'b10, NOT = 2'b11;

  // {uop, mem_data, mem_addr, n, z}
  localparam logic [49:0] VEC [NV] = '{
    {mk(0,PAS,0,1,0,0,0,0,6), 16'h0001, 12'h000, 1'b0, 1'b0}, // R2
    {mk(0,PAS,0,1,0,0,0,0,7), 16'hFFFF, 12'h000, 1'b1, 1'b0}, // R2
    {mk(0,PAS,0,1,0,0,0,0,8), 16'h0FFF, 12'h000, 1'b0, 1'b0}, // R2
    {mk(0,PAS,0,1,0,0,0,0,9), 16'h00FF, 12'h000, 1'b0, 1'b0}, // R2
    {mk(0,PAS,0,1,0,0,0,0,5), 16'h0000, 12'h000, 1'b0, 1'b1}, // R2
    {mk(0,PAS,0,0,0,1,1,0,7), 16'h0000, 12'h000, 1'b1, 1'b0}, // R11
    {mk(0,PAS,0,1,0,0,0,0,1), 16'hFFFF, 12'h000, 1'b1, 1'b0}, // R1
    {mk(0,ADD,0,1,0,1,7,6,6), 16'h0002, 12'h000, 1'b0, 1'b0}, // R3
    {mk(0,PAS,0,1,0,0,0,0,7), 16'hFFFF, 12'h000, 1'b1, 1'b0}, // R3
    {mk(0,ADD,0,1,0,0,0,6,1), 16'h0000, 12'h000, 1'b0, 1'b1}, // R4
    {mk(0,AND,0,1,0,0,0,9,8), 16'h00FF, 12'h000, 1'b0, 1'b0}, // R4
    {mk(0,NOT,0,1,0,0,0,0,9), 16'hFF00, 12'h000, 1'b1, 1'b0}, // R4
    {mk(0,PAS,1,1,0,0,0,0,7), 16'h7FFF, 12'h000, 1'b1, 1'b0}, // R5 R7
    {mk(0,PAS,2,1,0,0,0,0,6), 16'h0002, 12'h000, 1'b0, 1'b0}, // R5
    {mk(0,PAS,1,1,0,0,0,0,6), 16'h0000, 12'h000, 1'b0, 1'b0}, // R7
    {mk(0,PAS,3,1,0,0,0,0,9), 16'h00FF, 12'h000, 1'b0, 1'b0}, // R5
    {mk(1,ADD,0,1,0,0,0,6,0), 16'h0100, 12'h000, 1'b0, 1'b0}, // R6
    {mk(0,PAS,0,0,1,0,0,7,5), 16'h0100, 12'hFFF, 1'b0, 1'b1}, // R8
    {mk(0,PAS,0,0,0,0,0,6,6), 16'h0100, 12'hFFF, 1'b0, 1'b0}, // R8
    {mk(0,PAS,0,0,0,0,0,0,7), 16'h0100, 12'hFFF, 1'b1, 1'b0}, // R9
    {mk(0,PAS,0,1,0,0,0,0,0), 16'h0000, 12'hFFF, 1'b0, 1'b1}, // R9
    {mk(0,PAS,0,0,0,1,1,0,6), 16'h0000, 12'hFFF, 1'b0, 1'b0}, // R10
    {mk(0,ADD,0,1,0,1,1,1,1), 16'h0002, 12'hFFF, 1'b0, 1'b0}, // R10
    {mk(0,PAS,0,1,0,0,0,0,1), 16'h0002, 12'hFFF, 1'b0, 1'b0}, // R10
    {mk(0,PAS,0,0,0,1,15,0,8), 16'h0002, 12'hFFF, 1'b0, 1'b0}, // R1
    {mk(0,PAS,0,1,0,0,0,0,15), 16'h0FFF, 12'hFFF, 1'b0, 1'b0}, // R1
    {mk(1,PAS,0,1,0,0,0,0,0), 16'h0FFF, 12'hFFF, 1'b0, 1'b0}   // R6
  };

  task automatic drive(input logic [19:0] u);
    {uf_amux, uf_alu, uf_shift, uf_mbr_ld, uf_mar_ld, uf_enc,
     uf_csel, uf_bsel, uf_asel} = u;
  endtask

  // one microcycle: fields held across the phase-0 edge, sampled after phase 3
  task automatic run(input logic [19:0] u);
    drive(u);
    repeat (4) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R12 reset data", 32'(mem_data), 32'h0);
    chk("R12 reset addr", 32'(mem_addr), 32'h0);
    chk("R12 reset flags", 32'({flag_n, flag_z}), 32'h0);
    chk("R12 reset phase", 32'(phase), 32'h0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      run(VEC[i][49:30]);
      chk($sformatf("vec%0d data", i), 32'(mem_data), 32'(VEC[i][29:14]));
      chk($sformatf("vec%0d addr", i), 32'(mem_addr), 32'(VEC[i][13:2]));
      chk($sformatf("vec%0d flags", i), 32'({flag_n, flag_z}), 32'(VEC[i][1:0]));
    end

    // R12: phase sequence and capture only at the phase-0 edge
    chk("R12 phase at start", 32'(phase), 32'h0);
    drive(mk(0, PAS, 0, 1, 0, 0, 0, 0, 6));
    @(posedge clk);
    @(negedge clk);
    chk("R12 phase after one edge", 32'(phase), 32'h1);
    drive(mk(0, PAS, 0, 1, 0, 0, 0, 0, 7));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R12 late field change ignored", 32'(mem_data), 32'h0001);

    // R12 / R1: reset mid-run clears state and scratch registers
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk("R12 re-reset data", 32'(mem_data), 32'h0);
    chk("R12 re-reset addr", 32'(mem_addr), 32'h0);
    rst = 1'b0;
    run(mk(0, PAS, 0, 1, 0, 0, 0, 0, 15));
    chk("R1 scratch cleared", 32'(mem_data), 32'h0);
    chk("R1 zero flag", 32'(flag_z), 32'h1);
    run(mk(0, PAS, 0, 1, 0, 0, 0, 0, 9));
    chk("R2 constant survives reset", 32'(mem_data), 32'h00FF);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule